// File: doc/BRIEF.md
# Thread Interrupt Presentation Context

This block holds the interrupt presentation state of one hardware thread for two privilege rings: an operating-system ring (ring 0) and a hypervisor physical ring (ring 1). Each ring keeps four 8-bit registers. The pending bitmap records which of the eight priorities have outstanding work for this exact virtual processor. The pending-priority register holds the most favored priority currently on offer. The current-priority register is the threshold the software is running at. The status register records why and how an exception was raised.

A priority is a number from 0 to 7, and 0 is the most favored. Bitmap bit (7 - p) marks priority p as pending. The value 0xFF in the pending-priority or current-priority register means "nothing pending" or "nothing masked".

All operations arrive on one command channel that uses a valid/ready handshake. Each command carries a ring select and an opcode:

- A presentation delivers a priority. The target is either one virtual processor or a group. For a group, the block derives the group level from the target index.
- An accept acknowledges the interrupt on its ring. It produces a 16-bit response on a second valid/ready channel.
- A threshold write sets the current priority of the selected ring.

The per-ring exception outputs are plain level signals. The response channel holds one entry. While that entry is valid and `rsp_ready` is low, `cmd_ready` is low and every command stalls, whatever its opcode, so no accept response is ever dropped.

Top module: `tctx_present`

## Requirements
- R1: After reset, both rings have an empty pending bitmap, and their pending-priority and current-priority registers read 0xFF. Their status registers are 0 and both exception outputs are low. An accept on either ring then returns 16'h00FF.
- R2: A presentation with the group flag low sets bitmap bit (7 - priority). It then recomputes the pending priority as the most favored priority set in the bitmap.
- R3: A presentation with the group flag high leaves the bitmap untouched and loads the pending priority directly from the request priority.
- R4: After a presentation or a threshold write, the ring raises its exception output only when the new pending priority is numerically below the current priority. Otherwise the status register and the exception output keep their values.
- R5: Raising on ring 0 writes status = 8'h80 OR the 6-bit group level. Raising on ring 1 writes status = 2'b01 in bits 7:6, with the 6-bit group level in bits 5:0.
- R6: An accept always lowers the ring's exception output. If the status register is nonzero, the accept copies the pending priority into the current priority and then clears the status register to zero. The response is {status before accept, current priority after accept}.
- R7: If the accepted status has a zero group-level field (bits 5:0), the accept clears the bitmap bit of the accepted priority. If that field is nonzero, no bitmap bit changes.
- R8: For a group presentation, the group level is the number of consecutive one bits at the low end of `cmd_index`, plus one, taken modulo 64. A presentation to a single processor uses level 0.
- R9: A threshold write loads the current priority and recomputes the pending priority from the bitmap. It re-evaluates R4 with group level 0. It never lowers an exception output.
- R10: A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low exactly while a response is valid and `rsp_ready` is low. The response of an accept is valid on the cycle after the accept is taken, and it holds stable until it is taken.
- R11: Opcode 3 is reserved. A command with that opcode changes no state and no output.
- R12: The rings are independent. A command on one ring never changes the other ring's state or exception output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_op | input | 2 | 0 present, 1 accept, 2 threshold write, 3 reserved |
| cmd_ring | input | 1 | 0 operating-system ring, 1 hypervisor physical ring |
| cmd_prio | input | 3 | Presentation priority |
| cmd_group | input | 1 | Presentation targets a group |
| cmd_index | input | IDX_W | Target index used to derive the group level |
| cmd_cppr | input | 8 | Value for a threshold write |
| rsp_valid | output | 1 | Accept response available |
| rsp_ready | input | 1 | Response consumer can take it |
| rsp_data | output | 16 | {status before accept, current priority after accept} |
| irq_o | output | 2 | Exception output per ring, bit 0 is ring 0 |

## Verification
The hardest state to reach from the ports is a bitmap bit that survives an accept. To get there, a ring must take a direct and a group presentation at the same priority, so that the group one sets the status level. The accept must then see that nonzero level, and a later threshold write must expose the bit that was left behind. A directed sequence builds exactly this case and compares the responses against literal values. Back-pressure is also hard to reach, because a held response has to meet a command that arrives while it is held. A directed step and randomly lowered `rsp_ready` in the random phase both create that collision, and the random phase mixes all opcodes, both rings and index patterns with varied trailing-one runs.

// File: rtl/tctx_pkg.sv
package tctx_pkg;
  localparam int REG_W = 8;
  localparam logic [REG_W-1:0] PRIO_NONE = 8'hFF;

  typedef enum logic [1:0] {
    OP_PRESENT  = 2'd0,
    OP_ACCEPT   = 2'd1,
    OP_SET_CPPR = 2'd2,
    OP_RSVD     = 2'd3
  } tctx_op_e;

  // Exception code placed in the status register when a ring raises.
  function automatic logic [REG_W-1:0] exc_code(input int ring);
    return (ring == 0) ? 8'h80 : 8'h40;
  endfunction
endpackage

// File: rtl/tctx_group_level.sv
module tctx_group_level #(
  parameter int IDX_W = 16,
  parameter int LVL_W = 6
) (
  input  logic [IDX_W-1:0] index_i,
  output logic [LVL_W-1:0] level_o
);
  logic [31:0] run;
  logic        stop;
  logic [31:0] lvl_full;

  // Count ones at the low end of the index until the first zero.
  always_comb begin
    run  = '0;
    stop = 1'b0;
    for (int i = 0; i < IDX_W; i++) begin
      if (!stop) begin
        if (index_i[i]) run = run + 32'd1;
        else            stop = 1'b1;
      end
    end
    lvl_full = run + 32'd1;
    level_o  = lvl_full[LVL_W-1:0];
  end
endmodule

// File: rtl/tctx_prio_enc.sv
module tctx_prio_enc #(
  parameter int PRIO_W = 3
) (
  input  logic [(1<<PRIO_W)-1:0] pend_i,
  output logic [7:0]             prio_o
);
  import tctx_pkg::*;
  localparam int N = 1 << PRIO_W;

  // Bit (N-1-p) marks priority p. A higher bit is more favored,
  // and the last hit in the ascending scan wins.
  always_comb begin
    prio_o = PRIO_NONE;
    for (int i = 0; i < N; i++) begin
      if (pend_i[i]) prio_o = 8'(N - 1 - i);
    end
  end
endmodule

// File: rtl/tctx_ring.sv
module tctx_ring #(
  parameter int         PRIO_W = 3,
  parameter int         LVL_W  = 6,
  parameter logic [7:0] EXC    = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              present_i,
  input  logic              accept_i,
  input  logic              cppr_wr_i,
  input  logic [PRIO_W-1:0] prio_i,
  input  logic [LVL_W-1:0]  level_i,
  input  logic [7:0]        cppr_i,
  output logic              irq_o,
  output logic [15:0]       acc_rsp_o
);
  import tctx_pkg::*;
  localparam int N = 1 << PRIO_W;

  logic [N-1:0] ipb_q, ipb_d;
  logic [7:0]   pipr_q, pipr_d;
  logic [7:0]   cppr_q, cppr_d;
  logic [7:0]   nsr_q, nsr_d;
  logic         irq_q, irq_d;

  logic [N-1:0] req_bit;
  logic [N-1:0] acc_bit;
  logic [N-1:0] ipb_src;
  logic [7:0]   enc_pipr;
  logic         direct;
  logic [7:0]   cppr_after_acc;
  logic [7:0]   lvl_ext;

  assign direct  = present_i && (level_i == '0);
  assign lvl_ext = 8'(level_i);

  always_comb begin
    req_bit = '0;
    acc_bit = '0;
    for (int i = 0; i < N; i++) begin
      if (32'(prio_i) == N - 1 - i) req_bit[i] = 1'b1;
      if (32'(pipr_q) == N - 1 - i) acc_bit[i] = 1'b1;
    end
  end

  assign ipb_src = direct ? (ipb_q | req_bit) : ipb_q;

  tctx_prio_enc #(.PRIO_W(PRIO_W)) u_enc (
    .pend_i (ipb_src),
    .prio_o (enc_pipr)
  );

  assign cppr_after_acc = (nsr_q != '0) ? pipr_q : cppr_q;
  assign acc_rsp_o      = {nsr_q, cppr_after_acc};

  always_comb begin
    ipb_d  = ipb_q;
    pipr_d = pipr_q;
    cppr_d = cppr_q;
    nsr_d  = nsr_q;
    irq_d  = irq_q;
    if (present_i) begin
      ipb_d  = ipb_src;
      pipr_d = direct ? enc_pipr : 8'(prio_i);
      if (pipr_d < cppr_q) begin
        nsr_d = EXC | lvl_ext;
        irq_d = 1'b1;
      end
    end else if (cppr_wr_i) begin
      cppr_d = cppr_i;
      pipr_d = enc_pipr;
      if (enc_pipr < cppr_i) begin
        nsr_d = EXC;
        irq_d = 1'b1;
      end
    end else if (accept_i) begin
      irq_d = 1'b0;
      if (nsr_q != '0) begin
        cppr_d = pipr_q;
        if (nsr_q[5:0] == 6'd0) ipb_d = ipb_q & ~acc_bit;
        nsr_d = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ipb_q  <= '0;
      pipr_q <= PRIO_NONE;
      cppr_q <= PRIO_NONE;
      nsr_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      ipb_q  <= ipb_d;
      pipr_q <= pipr_d;
      cppr_q <= cppr_d;
      nsr_q  <= nsr_d;
      irq_q  <= irq_d;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/tctx_present.sv
module tctx_present #(
  parameter int IDX_W  = 16,
  parameter int PRIO_W = 3,
  parameter int LVL_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic              cmd_ring,
  input  logic [PRIO_W-1:0] cmd_prio,
  input  logic              cmd_group,
  input  logic [IDX_W-1:0]  cmd_index,
  input  logic [7:0]        cmd_cppr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [15:0]       rsp_data,
  output logic [1:0]        irq_o
);
  import tctx_pkg::*;
  localparam int RINGS = 2;

  logic             fire;
  tctx_op_e         op;
  logic [LVL_W-1:0] grp_level;
  logic [LVL_W-1:0] level;
  logic [15:0]      ring_rsp [RINGS];
  logic             rsp_valid_q;
  logic [15:0]      rsp_data_q;

  assign op        = tctx_op_e'(cmd_op);
  assign cmd_ready = !rsp_valid_q || rsp_ready;
  assign fire      = cmd_valid && cmd_ready;

  tctx_group_level #(.IDX_W(IDX_W), .LVL_W(LVL_W)) u_lvl (
    .index_i (cmd_index),
    .level_o (grp_level)
  );

  assign level = cmd_group ? grp_level : '0;

  for (genvar g = 0; g < RINGS; g++) begin : g_ring
    logic sel;
    assign sel = fire && (32'(cmd_ring) == g);
    tctx_ring #(
      .PRIO_W (PRIO_W),
      .LVL_W  (LVL_W),
      .EXC    (exc_code(g))
    ) u_ring (
      .clk       (clk),
      .rst_n     (rst_n),
      .present_i (sel && op == OP_PRESENT),
      .accept_i  (sel && op == OP_ACCEPT),
      .cppr_wr_i (sel && op == OP_SET_CPPR),
      .prio_i    (cmd_prio),
      .level_i   (level),
      .cppr_i    (cmd_cppr),
      .irq_o     (irq_o[g]),
      .acc_rsp_o (ring_rsp[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else if (fire && op == OP_ACCEPT) begin
      rsp_valid_q <= 1'b1;
      rsp_data_q  <= ring_rsp[cmd_ring];
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
endmodule

// File: rtl/tctx_present_chk.sv
module tctx_present_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [1:0]  cmd_op,
  input logic        cmd_ring,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [15:0] rsp_data,
  input logic [1:0]  irq_o
);
  logic taken, acc0, acc1, raising;
  assign taken   = cmd_valid && cmd_ready;
  assign acc0    = taken && cmd_op == 2'd1 && !cmd_ring;
  assign acc1    = taken && cmd_op == 2'd1 && cmd_ring;
  assign raising = taken && (cmd_op == 2'd0 || cmd_op == 2'd2);

  a_r6_accept_lowers_r0: assert property (@(posedge clk) disable iff (!rst_n)
    acc0 |=> !irq_o[0]);
  a_r6_accept_lowers_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc1 |=> !irq_o[1]);
  a_r10_rsp_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (acc0 || acc1) |=> rsp_valid);
  a_r10_rsp_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
  a_r10_rsp_only_from_accept: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc0 || acc1) |=> !$rose(rsp_valid));
  a_r11_no_spurious_raise: assert property (@(posedge clk) disable iff (!rst_n)
    !raising |=> (!$rose(irq_o[0]) && !$rose(irq_o[1])));
endmodule

bind tctx_present tctx_present_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_op    (cmd_op),
  .cmd_ring  (cmd_ring),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data),
  .irq_o     (irq_o)
);

// File: tb/tb_tctx_present.sv
module tb_tctx_present;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = 2'd0;
  logic        cmd_ring = 1'b0;
  logic [2:0]  cmd_prio = 3'd0;
  logic        cmd_group = 1'b0;
  logic [15:0] cmd_index = 16'd0;
  logic [7:0]  cmd_cppr = 8'd0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [15:0] rsp_data;
  logic [1:0]  irq_o;

  always #2.5 clk = ~clk;

  tctx_present dut (.*);

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Reference state
  logic [7:0]  m_ipb [2];
  logic [7:0]  m_pipr [2];
  logic [7:0]  m_cppr [2];
  logic [7:0]  m_nsr [2];
  logic        m_irq [2];
  bit          pend;
  logic [15:0] exp_rsp;
  logic [15:0] last_rsp;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] m_enc(input logic [7:0] v);
    logic [7:0] r = 8'hFF;
    for (int i = 7; i >= 0; i--) if (v[7-i]) r = 8'(i);
    return r;
  endfunction

  function automatic logic [5:0] m_level(input logic [15:0] idx);
    int n = 0;
    bit stop = 0;
    for (int i = 0; i < 16; i++) begin
      if (!stop && idx[i]) n++;
      else stop = 1;
    end
    return 6'((n + 1) % 64);
  endfunction

  task automatic model_apply(input logic [1:0] op, input bit r, input logic [2:0] p,
                             input bit g, input logic [15:0] idx, input logic [7:0] cv);
    logic [7:0] exc = r ? 8'h40 : 8'h80;
    logic [5:0] lvl;
    case (op)
      2'd0: begin
        lvl = g ? m_level(idx) : 6'd0;
        if (lvl == 0) begin
          m_ipb[r]  = m_ipb[r] | (8'd1 << (7 - p));
          m_pipr[r] = m_enc(m_ipb[r]);
        end else m_pipr[r] = {5'd0, p};
        if (m_pipr[r] < m_cppr[r]) begin
          m_nsr[r] = exc | {2'b00, lvl};
          m_irq[r] = 1'b1;
        end
      end
      2'd1: begin
        logic [7:0] old = m_nsr[r];
        m_irq[r] = 1'b0;
        if (old != 0) begin
          m_cppr[r] = m_pipr[r];
          if (old[5:0] == 0 && m_pipr[r] < 8) m_ipb[r] = m_ipb[r] & ~(8'd1 << (7 - m_pipr[r]));
          m_nsr[r] = 8'd0;
        end
        exp_rsp = {old, m_cppr[r]};
        pend = 1;
      end
      2'd2: begin
        m_cppr[r] = cv;
        m_pipr[r] = m_enc(m_ipb[r]);
        if (m_pipr[r] < cv) begin
          m_nsr[r] = exc;
          m_irq[r] = 1'b1;
        end
      end
      default: ;
    endcase
  endtask

  // One cycle: drive at the falling edge, evaluate, cross the rising edge, check.
  task automatic step(input bit v, input logic [1:0] op, input bit r, input logic [2:0] p,
                      input bit g, input logic [15:0] idx, input logic [7:0] cv,
                      input bit rr, input string tag);
    bit exp_ready;
    cmd_valid = v; cmd_op = op; cmd_ring = r; cmd_prio = p;
    cmd_group = g; cmd_index = idx; cmd_cppr = cv; rsp_ready = rr;
    #1;
    exp_ready = !(pend && !rr);
    chk(cmd_ready == exp_ready, "R10 cmd_ready", cmd_ready, exp_ready);
    if (pend) chk(rsp_data == exp_rsp, {"R6 response ", tag}, rsp_data, exp_rsp);
    if (pend && rr) begin
      last_rsp = rsp_data;
      pend = 0;
    end
    if (v && exp_ready) model_apply(op, r, p, g, idx, cv);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(irq_o == {m_irq[1], m_irq[0]}, {"R4 R12 irq ", tag}, irq_o, {m_irq[1], m_irq[0]});
    chk(rsp_valid == pend, "R10 rsp_valid", rsp_valid, pend);
  endtask

  task automatic idle();
    step(0, 2'd0, 0, 3'd0, 0, 16'd0, 8'd0, 1, "idle");
  endtask

  task automatic accept_and_get(input bit r, input logic [15:0] exp, input string tag);
    step(1, 2'd1, r, 3'd0, 0, 16'd0, 8'd0, 1, tag);
    idle();
    chk(last_rsp == exp, tag, last_rsp, exp);
  endtask

  initial begin
    #500000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int r = 0; r < 2; r++) begin
      m_ipb[r] = 0; m_pipr[r] = 8'hFF; m_cppr[r] = 8'hFF; m_nsr[r] = 0; m_irq[r] = 0;
    end
    pend = 0; exp_rsp = 0; last_rsp = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(irq_o == 2'b00, "R1 reset irq", irq_o, 0);
    chk(rsp_valid == 1'b0, "R1 reset rsp_valid", rsp_valid, 0);
    accept_and_get(0, 16'h00FF, "R1 reset accept ring0");
    accept_and_get(1, 16'h00FF, "R1 reset accept ring1");

    // Direct presentation on ring 0
    step(1, 2'd0, 0, 3'd3, 0, 16'd0, 8'd0, 1, "R2 present p3");
    chk(irq_o[0] == 1'b1, "R2 raise ring0", irq_o[0], 1);
    chk(irq_o[1] == 1'b0, "R12 ring1 untouched", irq_o[1], 0);
    accept_and_get(0, 16'h8003, "R5 R6 accept ring0 p3");
    step(1, 2'd0, 0, 3'd5, 0, 16'd0, 8'd0, 1, "R2 present p5");
    step(1, 2'd0, 0, 3'd2, 0, 16'd0, 8'd0, 1, "R2 present p2");
    accept_and_get(0, 16'h8002, "R2 most favored");
    accept_and_get(0, 16'h0002, "R6 accept with idle status");
    step(1, 2'd2, 0, 3'd0, 0, 16'd0, 8'hFF, 1, "R9 threshold open");
    chk(irq_o[0] == 1'b1, "R9 write raises", irq_o[0], 1);
    accept_and_get(0, 16'h8005, "R7 R9 remaining p5");

    // Group presentation on ring 1
    step(1, 2'd0, 1, 3'd1, 1, 16'h0007, 8'd0, 1, "R3 group p1");
    accept_and_get(1, 16'h4401, "R5 R8 group level 4");
    step(1, 2'd2, 1, 3'd0, 0, 16'd0, 8'hFF, 1, "R3 threshold after group");
    chk(irq_o[1] == 1'b0, "R3 bitmap untouched by group", irq_o[1], 0);
    step(1, 2'd0, 1, 3'd4, 0, 16'd0, 8'd0, 1, "R2 direct p4 ring1");
    step(1, 2'd0, 1, 3'd4, 1, 16'h0001, 8'd0, 1, "R8 group level 2");
    accept_and_get(1, 16'h4204, "R7 group accept");
    step(1, 2'd2, 1, 3'd0, 0, 16'd0, 8'hFF, 1, "R7 expose kept bit");
    accept_and_get(1, 16'h4004, "R7 bit kept after group accept");

    // Masking: threshold 0 blocks everything
    step(1, 2'd2, 0, 3'd0, 0, 16'd0, 8'h00, 1, "R4 threshold 0");
    step(1, 2'd0, 0, 3'd0, 0, 16'd0, 8'd0, 1, "R4 masked present");
    chk(irq_o[0] == 1'b0, "R4 no raise when equal", irq_o[0], 0);
    step(1, 2'd3, 0, 3'd1, 1, 16'h00FF, 8'h77, 1, "R11 reserved op");
    accept_and_get(0, 16'h0000, "R11 reserved op no effect");

    // Back-pressure
    step(1, 2'd1, 1, 3'd0, 0, 16'd0, 8'd0, 0, "R10 accept held");
    step(1, 2'd0, 1, 3'd2, 0, 16'd0, 8'd0, 0, "R10 stalled present");
    chk(irq_o[1] == 1'b0, "R10 stalled present not taken", irq_o[1], 0);
    idle();
    chk(last_rsp == 16'h0004, "R10 held response", last_rsp, 16'h0004);

    // Constrained random phase
    for (int n = 0; n < 3000; n++) begin
      logic [1:0]  op  = 2'($urandom_range(0, 3));
      logic [15:0] idx = 16'((32'd1 << $urandom_range(0, 6)) - 1);
      logic [7:0]  cv  = ($urandom_range(0, 3) == 0) ? 8'hFF : 8'($urandom_range(0, 7));
      if ($urandom_range(0, 7) == 0) idx = 16'($urandom);
      step($urandom_range(0, 4) != 0, op, 1'($urandom), 3'($urandom), 1'($urandom),
           idx, cv, $urandom_range(0, 3) != 0, "random");
    end
    repeat (2) idle();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule